// File: doc/BRIEF.md
# USB Link Activity LED Controller

This block turns a handful of USB device link indications into the drive for a single status LED. Once the device holds a bus address, the lamp burns steadily. Every handshake-acknowledged packet darkens it for a fixed window, so traffic shows as flicker. Before an address exists, each enumeration event lights the lamp for a short window over an otherwise dark background. While the link is suspended, the lamp is dark no matter what else happens.

Straight after reset, and whenever no address is held and enumeration has not begun, the lamp is on. Window lengths are given in milliseconds and converted to clock counts from the clock frequency parameter. A simulation build uses a reduced frequency so that the windows stay short. The output is a pin level whose sense is chosen by a parameter; the default is active-low, suited to an open-drain pad that sinks LED current.

Top module: `link_led_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the lamp is on. With the active-low default, `led_pin` is 0 when lit and 1 when dark.
- R2: With `addr_set` high and `suspend` low, the lamp is lit steadily whenever no acknowledge window is running.
- R3: An `ack_pulse` sampled while `addr_set` is high and `suspend` is low darkens the lamp from the next cycle. The lamp stays dark for exactly OFF_MS*CLK_HZ/1000 cycles.
- R4: An `ack_pulse` that arrives during a running dark window restarts that window at its full length.
- R5: `suspend` high darkens the lamp from the next cycle and for as long as it is held. `ack_pulse` and `enum_evt` sampled during suspend have no effect, then or later.
- R6: When suspend is entered, any running window is cancelled. When suspend ends, the lamp returns to the state that matches `addr_set`: steadily lit with an address, idle-lit without one.
- R7: An `enum_evt` sampled with `addr_set` low and `suspend` low lights the lamp for exactly ON_MS*CLK_HZ/1000 cycles. After that the lamp is dark until the next event. A new event during the window restarts the window.
- R8: An `ack_pulse` sampled while `addr_set` is low has no effect on the lamp.
- R9: When `addr_set` falls with `suspend` low, the controller returns to the idle-lit state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| enum_evt | input | 1 | One-cycle pulse per enumeration event |
| addr_set | input | 1 | Level, high once the device address is assigned |
| ack_pulse | input | 1 | One-cycle pulse per acknowledged packet |
| suspend | input | 1 | Level, high while the link is suspended |
| led_pin | output | 1 | LED drive level (low = lit by default) |

## Verification
The hardest situations to reach are the window edges and the restarts. A window ends only after thousands of cycles, and a restart must be told apart from the original expiry. The stimulus table therefore lets each entry wait for a count of edges. Entries are placed one cycle before and one cycle after each expected expiry. A retrigger entry comes partway through a window, and the following checks sample at a point where the first window would already have ended but the restarted one is still running. Pulses sent during suspend are followed by a release of suspend. After the release, the lamp is checked to confirm that no window was started behind the dark lamp.

// File: rtl/link_led_pkg.sv
package link_led_pkg;

   typedef enum logic [1:0] {
      MD_IDLE = 2'd0,
      MD_ENUM = 2'd1,
      MD_CONF = 2'd2,
      MD_SUSP = 2'd3
   } link_mode_t;

   localparam int unsigned HZ_PER_KHZ = 1000;

endpackage

// File: rtl/lnk_link_mode.sv
module lnk_link_mode
   import link_led_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       suspend,
   input  logic       addr_set,
   input  logic       enum_evt,
   output link_mode_t mode_q,
   output link_mode_t mode_d
);

   // Priority: suspend, then address, then enumeration activity.
   always_comb begin
      if (suspend) begin
         mode_d = MD_SUSP;
      end else if (addr_set) begin
         mode_d = MD_CONF;
      end else if (enum_evt || (mode_q == MD_ENUM)) begin
         mode_d = MD_ENUM;
      end else begin
         mode_d = MD_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_IDLE;
      end else begin
         mode_q <= mode_d;
      end
   end

endmodule

// File: rtl/lnk_ms_window.sv
module lnk_ms_window #(
   parameter int unsigned DIV = 48000,
   parameter int unsigned MS  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clear,
   output logic active
);

   localparam int unsigned MSW = $clog2(MS + 1);

   logic [MSW-1:0] ms_q;
   logic           tick;

   assign active = (ms_q != '0);

   generate
      if (DIV > 1) begin : g_presc
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] presc_q;

         assign tick = (presc_q == PW'(DIV - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               presc_q <= '0;
            end else if (clear || start || tick || !active) begin
               presc_q <= '0;
            end else begin
               presc_q <= presc_q + 1'b1;
            end
         end
      end else begin : g_nopresc
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_q <= '0;
      end else if (clear) begin
         ms_q <= '0;
      end else if (start) begin
         ms_q <= MSW'(MS);
      end else if (active && tick) begin
         ms_q <= ms_q - 1'b1;
      end
   end

endmodule

// File: rtl/lnk_led_stage.sv
module lnk_led_stage #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic lit,
   output logic pin
);

   generate
      if (ACTIVE_LOW) begin : g_sink
         assign pin = ~lit;
      end else begin : g_source
         assign pin = lit;
      end
   endgenerate

endmodule

// File: rtl/link_led_ctrl.sv
module link_led_ctrl
   import link_led_pkg::*;
#(
   parameter int unsigned CLK_HZ         = 48_000_000,
   parameter int unsigned OFF_MS         = 100,
   parameter int unsigned ON_MS          = 50,
   parameter bit          LED_ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enum_evt,
   input  logic addr_set,
   input  logic ack_pulse,
   input  logic suspend,
   output logic led_pin
);

   localparam int unsigned MS_DIV = CLK_HZ / HZ_PER_KHZ;

   generate
      if (MS_DIV < 1) begin : g_bad_clk
         $error("link_led_ctrl: CLK_HZ must be at least 1000");
      end
      if (OFF_MS < 1 || ON_MS < 1) begin : g_bad_win
         $error("link_led_ctrl: window lengths must be non-zero");
      end
   endgenerate

   link_mode_t mode_q;
   link_mode_t mode_d;
   logic       off_act;
   logic       on_act;
   logic       lit;

   lnk_link_mode u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .suspend  (suspend),
      .addr_set (addr_set),
      .enum_evt (enum_evt),
      .mode_q   (mode_q),
      .mode_d   (mode_d)
   );

   lnk_ms_window #(.DIV(MS_DIV), .MS(OFF_MS)) u_off_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (ack_pulse && (mode_d == MD_CONF)),
      .clear  (mode_d != MD_CONF),
      .active (off_act)
   );

   lnk_ms_window #(.DIV(MS_DIV), .MS(ON_MS)) u_on_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (enum_evt && (mode_d == MD_ENUM)),
      .clear  (mode_d != MD_ENUM),
      .active (on_act)
   );

   always_comb begin
      unique case (mode_q)
         MD_IDLE: lit = 1'b1;
         MD_ENUM: lit = on_act;
         MD_CONF: lit = !off_act;
         default: lit = 1'b0;
      endcase
   end

   lnk_led_stage #(.ACTIVE_LOW(LED_ACTIVE_LOW)) u_stage (
      .lit (lit),
      .pin (led_pin)
   );

endmodule

// File: rtl/link_led_chk.sv
module link_led_chk #(
   parameter bit LED_ACTIVE_LOW = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic enum_evt,
   input logic addr_set,
   input logic ack_pulse,
   input logic suspend,
   input logic led_pin
);

   logic lamp;
   assign lamp = (led_pin != LED_ACTIVE_LOW);

   always @(negedge rst_n) begin
      #1 AST_RESET_LIT: assert (rst_n || lamp); // R1
   end

   AST_SUSP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      suspend |=> !lamp); // R5

   AST_ACK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pulse && addr_set && !suspend) |=> !lamp); // R3

   AST_CONF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_set && !suspend && !ack_pulse && lamp) |=> lamp); // R2

   AST_RESUME_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(suspend) && addr_set && !ack_pulse) |=> lamp); // R6

   AST_ENUM_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      (enum_evt && !addr_set && !suspend) |=> lamp); // R7

endmodule

bind link_led_ctrl link_led_chk #(.LED_ACTIVE_LOW(LED_ACTIVE_LOW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enum_evt  (enum_evt),
   .addr_set  (addr_set),
   .ack_pulse (ack_pulse),
   .suspend   (suspend),
   .led_pin   (led_pin)
);

// File: tb/tb_link_led_ctrl.sv
module tb_link_led_ctrl;

   // Reduced clock rate: 50 cycles per ms, dark window 5000, lit window 2500.
   localparam int unsigned SIM_HZ = 50_000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enum_evt = 1'b0;
   logic addr_set = 1'b0;
   logic ack_pulse = 1'b0;
   logic suspend = 1'b0;
   logic led_pin;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   link_led_ctrl #(.CLK_HZ(SIM_HZ), .OFF_MS(100), .ON_MS(50), .LED_ACTIVE_LOW(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .enum_evt  (enum_evt),
      .addr_set  (addr_set),
      .ack_pulse (ack_pulse),
      .suspend   (suspend),
      .led_pin   (led_pin)
   );

   // Fields: req[24:21] susp[20] addr[19] ack[18] enum[17] edges[16:1] exp_pin[0]
   localparam int NV = 37;
   localparam logic [24:0] VEC [NV] = '{
      {4'd1, 4'b0000, 16'd1,    1'b0},  // R1 idle lit
      {4'd7, 4'b0001, 16'd1,    1'b0},  // R7 window start
      {4'd7, 4'b0000, 16'd2498, 1'b0},  // R7
      {4'd7, 4'b0000, 16'd1,    1'b0},  // R7 last lit cycle
      {4'd7, 4'b0000, 16'd1,    1'b1},  // R7 expiry
      {4'd7, 4'b0001, 16'd1,    1'b0},  // R7
      {4'd7, 4'b0000, 16'd1000, 1'b0},  // R7
      {4'd7, 4'b0001, 16'd1,    1'b0},  // R7 restart
      {4'd7, 4'b0000, 16'd2000, 1'b0},  // R7 past old expiry
      {4'd7, 4'b0000, 16'd499,  1'b0},  // R7
      {4'd7, 4'b0000, 16'd1,    1'b1},  // R7
      {4'd2, 4'b0100, 16'd1,    1'b0},  // R2 address held
      {4'd3, 4'b0110, 16'd1,    1'b1},  // R3 ack darkens
      {4'd3, 4'b0100, 16'd4998, 1'b1},  // R3
      {4'd3, 4'b0100, 16'd1,    1'b1},  // R3 last dark cycle
      {4'd3, 4'b0100, 16'd1,    1'b0},  // R3 expiry
      {4'd2, 4'b0100, 16'd100,  1'b0},  // R2 steady
      {4'd4, 4'b0110, 16'd1,    1'b1},  // R4
      {4'd4, 4'b0100, 16'd3000, 1'b1},  // R4
      {4'd4, 4'b0110, 16'd1,    1'b1},  // R4 restart
      {4'd4, 4'b0100, 16'd2500, 1'b1},  // R4 past old expiry
      {4'd4, 4'b0100, 16'd2499, 1'b1},  // R4
      {4'd4, 4'b0100, 16'd1,    1'b0},  // R4
      {4'd5, 4'b1100, 16'd1,    1'b1},  // R5 suspend dark
      {4'd5, 4'b1110, 16'd1,    1'b1},  // R5 ack in suspend
      {4'd5, 4'b1101, 16'd10,   1'b1},  // R5 enum in suspend
      {4'd6, 4'b0100, 16'd1,    1'b0},  // R6 resume lit, no window
      {4'd6, 4'b0110, 16'd1,    1'b1},  // R6 start blink
      {4'd6, 4'b1100, 16'd1,    1'b1},  // R6 suspend mid blink
      {4'd6, 4'b0100, 16'd1,    1'b0},  // R6 blink cancelled
      {4'd9, 4'b0000, 16'd1,    1'b0},  // R9 address dropped
      {4'd8, 4'b0010, 16'd1,    1'b0},  // R8 ack without address
      {4'd8, 4'b0000, 16'd10,   1'b0},  // R8
      {4'd6, 4'b1000, 16'd5,    1'b1},  // R6 suspend, no address
      {4'd6, 4'b1001, 16'd1,    1'b1},  // R6 enum ignored
      {4'd6, 4'b0000, 16'd1,    1'b0},  // R6 idle on resume
      {4'd6, 4'b0000, 16'd3000, 1'b0}   // R6 still idle
   };

   task automatic check(input int req, input logic exp);
      checks++;
      if (led_pin !== exp) begin
         errors++;
         $display("FAIL R%0d: led_pin=%b expected=%b at %0t", req, led_pin, exp, $time);
      end
   endtask

   initial begin
      #5_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check(1, 1'b0); // R1 lit during reset
      @(negedge clk);
      rst_n = 1'b1;
      for (int v = 0; v < NV; v++) begin
         suspend   = VEC[v][20];
         addr_set  = VEC[v][19];
         ack_pulse = VEC[v][18];
         enum_evt  = VEC[v][17];
         for (int e = 0; e < int'(VEC[v][16:1]); e++) begin
            @(posedge clk);
            @(negedge clk);
            ack_pulse = 1'b0;
            enum_evt  = 1'b0;
         end
         check(int'(VEC[v][24:21]), VEC[v][0]);
      end

      // R1: reset in the middle of a dark window brings the lamp back on
      addr_set  = 1'b1;
      ack_pulse = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ack_pulse = 1'b0;
      check(3, 1'b1); // R3
      rst_n = 1'b0;
      #1 check(1, 1'b0); // R1
      addr_set = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(1, 1'b0); // R1 first cycle after reset

      // R8: ack then address in the next cycle starts no window
      ack_pulse = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ack_pulse = 1'b0;
      addr_set  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(8, 1'b0); // R8

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule